// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port that hangs off a simple processor I/O bus. Software sees three locations: a data latch, a per-pin direction register and a read-only window onto the live pin levels. From the latch and direction bits the block derives three per-pin signals for the pad ring: output-enable, output value and pull-up enable. A pin whose direction bit is set becomes a push-pull output that drives its latch bit. A pin whose direction bit is clear is an input, and its latch bit then turns its weak pull-up on or off.

The bus is single-cycle. A write strobe with an address and a data byte updates a register at the next rising clock edge. A read strobe returns data combinationally in the same cycle. Pin levels pass through a two-stage synchroniser before they reach the read path, so a pin change is visible to software two clock edges later. Reset is asynchronous and active low. It clears both registers at once, even with the clock stopped, so every pin is tristated without waiting for an edge.

The block contains no state machine. The decoded register select is an enumerated type (none, pin view, direction, latch) that steers both the write enables and the read multiplexer.

Top module: `bidir_io_port`

## Requirements
- R1: While rst_n is low, the latch and the direction register are zero and pad_oe, pad_out and pad_pu are all zero, without waiting for a clock edge.
- R2: A write strobe to address 0x12 loads bus_wdata into the data latch at the next rising edge. A read at 0x12 returns the latch contents, not the pin levels.
- R3: A write strobe to address 0x11 loads bus_wdata into the direction register at the next rising edge. A read at 0x11 returns it.
- R4: A read at address 0x10 returns pad_in as it was sampled two rising edges earlier, through a two-stage synchroniser.
- R5: A write to 0x10, or to any address other than 0x11 and 0x12, changes neither the latch nor the direction register.
- R6: For each bit n, pad_oe[n] equals direction bit n. pad_out[n] equals latch bit n when direction bit n is 1, and 0 otherwise.
- R7: For each bit n with direction bit 0, pad_pu[n] equals latch bit n. Latch 0 therefore leaves the pin high-impedance with no pull-up.
- R8: pad_pu[n] is never 1 while pad_oe[n] is 1.
- R9: bus_rdata is 0 when bus_rd is low, and also when bus_rd is high at an address other than 0x10, 0x11 or 0x12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | I/O address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |
| pad_in | input | 8 | Pin levels from the pads, asynchronous |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The write-effect properties assume that bus_addr and bus_wdata are stable around the rising edge at which bus_wr is sampled. They also assume that no strobe is asserted during reset. The synchroniser property assumes only that pad_in has settled at each edge the simulation samples. The stimulus meets these assumptions: it changes bus and pad inputs one time unit after a rising edge and holds the strobes low while reset is active. It releases reset away from any clock edge and asserts reset in the middle of a cycle, so the tristate-on-reset check sees the outputs before any edge could have helped.

// File: rtl/iop_pkg.sv
package iop_pkg;
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_PIN   = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_LATCH = 2'd3
    } iop_sel_e;
endpackage

// File: rtl/iop_decode.sv
module iop_decode
    import iop_pkg::*;
#(
    parameter int                ADDR_W     = 6,
    parameter logic [ADDR_W-1:0] ADDR_PIN   = 6'h10,
    parameter logic [ADDR_W-1:0] ADDR_DIR   = 6'h11,
    parameter logic [ADDR_W-1:0] ADDR_LATCH = 6'h12
) (
    input  logic [ADDR_W-1:0] addr,
    output iop_sel_e          sel
);
    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_PIN)        sel = SEL_PIN;
        else if (addr == ADDR_DIR)   sel = SEL_DIR;
        else if (addr == ADDR_LATCH) sel = SEL_LATCH;
    end
endmodule

// File: rtl/iop_sync.sv
module iop_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

    // one edge seen since reset release, so $past is meaningful
    logic primed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // R4: first stage captures the pin level of the previous edge
    a_r4_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> stage_q[0] == $past(din))
        else $error("a_r4_first_stage");
endmodule

// File: rtl/iop_pad_ctrl.sv
module iop_pad_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] latch,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] out,
    output logic [WIDTH-1:0] pu
);
    generate
        for (genvar n = 0; n < WIDTH; n++) begin : g_pin
            always_comb begin
                oe[n]  = dir[n];
                out[n] = dir[n] & latch[n];
                pu[n]  = ~dir[n] & latch[n];
            end
        end
    endgenerate

    // R8: pull-up and driver never together on a pin
    a_r8_pu_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (pu & oe) == '0)
        else $error("a_r8_pu_excl");
endmodule

// File: rtl/bidir_io_port.sv
module bidir_io_port
    import iop_pkg::*;
#(
    parameter int                WIDTH      = 8,
    parameter int                ADDR_W     = 6,
    parameter int                SYNC_DEPTH = 2,
    parameter logic [ADDR_W-1:0] ADDR_PIN   = 6'h10,
    parameter logic [ADDR_W-1:0] ADDR_DIR   = 6'h11,
    parameter logic [ADDR_W-1:0] ADDR_LATCH = 6'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_pu
);
    iop_sel_e         sel;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;

    iop_decode #(
        .ADDR_W(ADDR_W), .ADDR_PIN(ADDR_PIN),
        .ADDR_DIR(ADDR_DIR), .ADDR_LATCH(ADDR_LATCH)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    iop_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_sync)
    );

    // register state: asynchronous clear tristates pins at once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_LATCH: latch_q <= bus_wdata;
                SEL_DIR:   dir_q   <= bus_wdata;
                SEL_PIN,
                SEL_NONE:  ;
                default:   ;
            endcase
        end
    end

    // read multiplexer, combinational
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_LATCH: bus_rdata = latch_q;
                SEL_DIR:   bus_rdata = dir_q;
                SEL_PIN:   bus_rdata = pin_sync;
                SEL_NONE:  bus_rdata = '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

    iop_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
        .clk   (clk),
        .rst_n (rst_n),
        .dir   (dir_q),
        .latch (latch_q),
        .oe    (pad_oe),
        .out   (pad_out),
        .pu    (pad_pu)
    );

    // R1: reset tristates and disables pull-ups
    always @(negedge clk) begin
        if (rst_n == 1'b0) begin
            a_r1_reset_tristate: assert (pad_oe == '0 && pad_pu == '0 && pad_out == '0)
                else $error("a_r1_reset_tristate");
        end
    end

    // R2: latch write lands at the next edge
    a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_LATCH) |=> latch_q == $past(bus_wdata))
        else $error("a_r2_latch_write");

    // R6: direction write shows on the output enables
    a_r6_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DIR) |=> pad_oe == $past(bus_wdata))
        else $error("a_r6_dir_to_oe");

    // R5: a write to the pin view alters no register
    a_r5_pin_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_PIN) |=> ($stable(latch_q) && $stable(dir_q)))
        else $error("a_r5_pin_write_inert");
endmodule

// File: tb/tb_bidir_io_port.sv
module tb_bidir_io_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pu;

    always #5 clk = ~clk;

    bidir_io_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    int n_chk = 0, n_bad = 0;
    int m_chk = 0, m_bad = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // scoreboard monitor: compares each strobed read against its expectation
    always @(negedge clk) begin
        if (bus_rd) begin
            m_chk++;
            if (exp_q.size() == 0) begin
                m_bad++;
                $display("FAIL read with no expectation: actual %h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    m_bad++;
                    $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk + m_chk, n_bad + m_bad);
            $finish;
        end
    end

    initial begin
        #23;
        check("R1 reset oe", pad_oe, 8'h00);
        check("R1 reset pu", pad_pu, 8'h00);
        check("R9 idle rdata", bus_rdata, 8'h00);
        #4 rst_n = 1'b1;
        do_read(6'h12, 8'h00, "R1 latch after reset");
        do_read(6'h11, 8'h00, "R1 dir after reset");

        // latch and direction writes and readback
        do_write(6'h12, 8'hA5);
        do_read(6'h12, 8'hA5, "R2 latch readback");
        do_write(6'h11, 8'h0F);
        do_read(6'h11, 8'h0F, "R3 dir readback");
        @(negedge clk);
        check("R6 oe", pad_oe, 8'h0F);
        check("R6 out", pad_out, 8'h05);
        check("R7 pu", pad_pu, 8'hA0);
        check("R8 pu&oe", pad_pu & pad_oe, 8'h00);

        // latch reads the latch, not the pins
        pad_in = 8'h3C;
        repeat (3) @(posedge clk);
        do_read(6'h12, 8'hA5, "R2 latch not pins");
        do_read(6'h10, 8'h3C, "R4 pin view");

        // ignored writes
        do_write(6'h10, 8'hFF);
        do_write(6'h20, 8'h00);
        do_write(6'h13, 8'h5A);
        do_read(6'h12, 8'hA5, "R5 latch kept");
        do_read(6'h11, 8'h0F, "R5 dir kept");
        do_read(6'h13, 8'h00, "R9 unmapped read");

        // all inputs, all outputs
        do_write(6'h11, 8'h00);
        do_write(6'h12, 8'hFF);
        @(negedge clk);
        check("R7 all pull-up", pad_pu, 8'hFF);
        check("R6 no drive", pad_oe, 8'h00);
        do_write(6'h12, 8'h00);
        @(negedge clk);
        check("R7 hi-z no pull", pad_pu, 8'h00);
        do_write(6'h11, 8'hFF);
        do_write(6'h12, 8'h96);
        @(negedge clk);
        check("R6 all out", pad_out, 8'h96);
        check("R8 pu off when out", pad_pu, 8'h00);

        // synchroniser lag, read strobe held
        @(posedge clk); #1;
        bus_addr = 6'h10; bus_rd = 1'b1;
        exp_q.push_back(8'h3C); tag_q.push_back("R4 lag cycle0");
        pad_in = 8'hC3;
        exp_q.push_back(8'h3C); tag_q.push_back("R4 lag one edge");
        exp_q.push_back(8'hC3); tag_q.push_back("R4 visible after two edges");
        @(negedge clk); @(negedge clk); @(negedge clk);
        #1 bus_rd = 1'b0;

        // asynchronous reset mid-cycle
        @(posedge clk); #3;
        rst_n = 1'b0;
        #1;
        check("R1 async oe", pad_oe, 8'h00);
        check("R1 async out", pad_out, 8'h00);
        @(posedge clk); #2 rst_n = 1'b1;
        do_read(6'h11, 8'h00, "R1 dir cleared");

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk + m_chk, n_bad + m_bad);
        $finish;
    end
endmodule